// File: doc/BRIEF.md
# Lock-State Command Permission Gate

This block guards the command path of a small secure store. It keeps an eight-bit lock byte, taken from an initial value while reset is held, and checks every decoded memory command against the operating mode that the two low bits of that byte select. For each command it reports one cycle later whether the command may proceed or must be refused. The block does not store data, encrypt, hash or check addresses. It only decides which commands may run, and it carries out the single one-way lock step.

The chip holds the lock byte in non-volatile cells and presents it as `init_lock` while reset is asserted. There are two unlocked modes. The open mode allows plain access. The confidential mode allows only protected access and hides plain reads. Neither unlocked mode can move into the other. A successful lock command drives the whole byte to all ones, and after that the byte stays frozen. The current byte is always visible, both on its own and joined to a fixed manufacturer identifier for the identification read.

The command side is a plain strobe with no back-pressure. The block accepts one command per cycle, every cycle, and each strobe produces exactly one response pulse on the following cycle.

Top module: `cmd_lock_gate`

## Requirements
- R1: While `rst_n` is low the lock byte loads `init_lock`. `lock_byte` always shows the current byte, and `id_word` always shows {MFR_ID, lock byte}, with the identifier in the upper eight bits.
- R2: When bits [1:0] of the lock byte are 11 (locked mode), plain read, plain write and identification read are permitted. Encrypted write, digest read and lock are refused.
- R3: When bits [1:0] are 10 (confidential mode), digest read, encrypted write, plain write, lock and identification read are permitted. Plain read is refused.
- R4: When bits [1:0] are 00 (open mode), plain read, plain write, lock and identification read are permitted. Encrypted write and digest read are refused.
- R5: No command other than a permitted lock changes the lock byte, so the byte never moves between the 10 and 00 modes.
- R6: A permitted lock sets the lock byte to 0xFF, visible on the cycle after the strobe. From then on the byte never changes.
- R7: A lock command issued while the mode is locked, including when the byte is 0xFF, is refused with `rsp_error` and leaves the byte unchanged.
- R8: An initial value whose bits [1:0] are 01 is treated as locked mode. `rsp_error` reads 1 out of reset and holds that value until the first response.
- R9: Opcodes are 0 plain read, 1 plain write, 2 encrypted write, 3 digest read, 4 lock, 5 identification read. Opcodes 6 and 7 are always refused. A `cmd_valid` strobe produces a one-cycle `rsp_valid` pulse on the next cycle. With that pulse exactly one of `rsp_permit` and `rsp_error` is 1, and both hold their values until the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the lock byte from `init_lock` |
| init_lock | input | 8 | Stored lock byte presented during reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Decoded command opcode (encoding in R9) |
| rsp_valid | output | 1 | Response strobe, one cycle after `cmd_valid` |
| rsp_permit | output | 1 | Last command was allowed |
| rsp_error | output | 1 | Last command was refused, or the initial byte was invalid |
| lock_byte | output | 8 | Current lock byte |
| id_word | output | 16 | {manufacturer ID, lock byte} |

## Verification
The bench sweeps every opcode, including the two unused codes, from every initial mode: open, confidential, the invalid 01 pattern, and locked values both with and without all-ones upper bits. It then repeats the sweep after the lock step. A design that treated 01 as unlocked would allow encrypted writes or a second lock from that state. A design that accepted a lock in locked mode would rewrite a byte such as 0x03 to 0xFF. The bench also checks that a refused command leaves the byte intact, which would catch an error path that mistakenly moved the byte between the two unlocked modes.

// File: rtl/lkg_pkg.sv
package lkg_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_RD_PLAIN  = 3'd0,
    OP_WR_PLAIN  = 3'd1,
    OP_WR_ENC    = 3'd2,
    OP_RD_DIGEST = 3'd3,
    OP_LOCK      = 3'd4,
    OP_RD_ID     = 3'd5,
    OP_RSVD6     = 3'd6,
    OP_RSVD7     = 3'd7
  } lkg_op_e;

  typedef enum logic [1:0] {
    MODE_OPEN   = 2'd0,
    MODE_CONF   = 2'd1,
    MODE_LOCKED = 2'd2
  } lkg_mode_e;
endpackage

// File: rtl/lkg_mode_decode.sv
module lkg_mode_decode
  import lkg_pkg::*;
#(
  parameter int LOCK_W = 8
) (
  input  logic [LOCK_W-1:0] lock_val,
  output lkg_mode_e         mode,
  output logic              bad_code
);
  // Bit 0 set means locked: 11 is the true locked code, 01 is mapped there fail-secure.
  always_comb begin
    bad_code = (lock_val[1:0] == 2'b01);
    unique case (lock_val[1:0])
      2'b00:   mode = MODE_OPEN;
      2'b10:   mode = MODE_CONF;
      default: mode = MODE_LOCKED;
    endcase
  end
endmodule

// File: rtl/lkg_perm_table.sv
module lkg_perm_table
  import lkg_pkg::*;
(
  input  lkg_mode_e mode,
  input  lkg_op_e   op,
  output logic      permit
);
  logic is_conf, is_locked;

  always_comb begin
    is_conf   = (mode == MODE_CONF);
    is_locked = (mode == MODE_LOCKED);
    unique case (op)
      OP_RD_PLAIN:  permit = !is_conf;
      OP_WR_PLAIN:  permit = 1'b1;
      OP_WR_ENC:    permit = is_conf;
      OP_RD_DIGEST: permit = is_conf;
      OP_LOCK:      permit = !is_locked;
      OP_RD_ID:     permit = 1'b1;
      default:      permit = 1'b0;
    endcase
  end
endmodule

// File: rtl/lkg_lock_reg.sv
module lkg_lock_reg #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOCK_W-1:0] init_val,
  input  logic              lock_fire,
  output logic [LOCK_W-1:0] lock_q
);
  localparam logic [LOCK_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lock_q <= init_val;
    else if (lock_fire) lock_q <= ALL_ONES;
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q == ALL_ONES) |=> (lock_q == ALL_ONES)); // R6
endmodule

// File: rtl/cmd_lock_gate.sv
module cmd_lock_gate
  import lkg_pkg::*;
#(
  parameter int              LOCK_W = 8,
  parameter int              ID_W   = 8,
  parameter logic [ID_W-1:0] MFR_ID = 8'h5A
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LOCK_W-1:0]      init_lock,
  input  logic                   cmd_valid,
  input  logic [OP_W-1:0]        cmd_op,
  output logic                   rsp_valid,
  output logic                   rsp_permit,
  output logic                   rsp_error,
  output logic [LOCK_W-1:0]      lock_byte,
  output logic [ID_W+LOCK_W-1:0] id_word
);
  localparam logic [LOCK_W-1:0] ALL_ONES = '1;

  lkg_mode_e mode_cur, mode_init;
  logic      bad_cur, bad_init;
  logic      permit_now, lock_fire;
  lkg_op_e   op_e;
  logic      arm_q;

  assign op_e = lkg_op_e'(cmd_op);

  lkg_mode_decode #(.LOCK_W(LOCK_W)) u_dec_cur (
    .lock_val(lock_byte), .mode(mode_cur), .bad_code(bad_cur));

  lkg_mode_decode #(.LOCK_W(LOCK_W)) u_dec_init (
    .lock_val(init_lock), .mode(mode_init), .bad_code(bad_init));

  lkg_perm_table u_perm (
    .mode(mode_cur), .op(op_e), .permit(permit_now));

  assign lock_fire = cmd_valid && (op_e == OP_LOCK) && permit_now;

  lkg_lock_reg #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .init_val(init_lock),
    .lock_fire(lock_fire), .lock_q(lock_byte));

  assign id_word = {MFR_ID, lock_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_permit <= 1'b0;
      rsp_error  <= bad_init;
      arm_q      <= 1'b0;
    end else begin
      rsp_valid <= cmd_valid;
      arm_q     <= 1'b1;
      if (cmd_valid) begin
        rsp_permit <= permit_now;
        rsp_error  <= !permit_now;
      end
    end
  end

  AST_RSP_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q && $past(cmd_valid) |-> rsp_valid); // R9

  AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_permit, rsp_error})); // R9

  AST_NO_MODE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q && !$stable(lock_byte) |-> (lock_byte == ALL_ONES)); // R5

  AST_LOCKED_REFUSE_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q && $past(cmd_valid) && $past(mode_cur == MODE_LOCKED)
    && ($past(op_e) == OP_WR_ENC || $past(op_e) == OP_RD_DIGEST) |-> rsp_error); // R2

  AST_RELOCK_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q && $past(cmd_valid) && $past(mode_cur == MODE_LOCKED)
    && ($past(op_e) == OP_LOCK) |-> rsp_error && $stable(lock_byte)); // R7
endmodule

// File: tb/sim_cmd_lock_gate.sv
`timescale 1ns/1ps
module sim_cmd_lock_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  init_lock = 8'h00;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        rsp_valid, rsp_permit, rsp_error;
  logic [7:0]  lock_byte;
  logic [15:0] id_word;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_byte;

  always #4 clk = ~clk;

  cmd_lock_gate u0 (
    .clk(clk), .rst_n(rst_n), .init_lock(init_lock),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .rsp_error(rsp_error),
    .lock_byte(lock_byte), .id_word(id_word));

  function automatic bit exp_permit(input logic [7:0] b, input int op);
    bit locked = b[0];
    bit conf   = (b[1:0] == 2'b10);
    case (op)
      0: return !conf;
      1: return 1'b1;
      2: return conf;
      3: return conf;
      4: return !locked;
      5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] v);
    @(negedge clk);
    rst_n = 1'b0;
    init_lock = v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_byte = v;
    #1;
    check("R1 reset byte", {24'd0, lock_byte}, {24'd0, v});
    check("R1 id word", {16'd0, id_word}, {16'd0, 8'h5A, v});
    check("R8 reset error", {31'd0, rsp_error}, {31'd0, (v[1:0] == 2'b01)});
    check("R9 idle valid", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic do_cmd(input int op);
    bit p;
    string tag;
    p = exp_permit(exp_byte, op);
    tag = exp_byte[0] ? "R2" : (exp_byte[1] ? "R3" : "R4");
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op[2:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R9 rsp valid", {31'd0, rsp_valid}, 32'd1);
    check({tag, " permit"}, {31'd0, rsp_permit}, {31'd0, p});
    check({tag, " error"}, {31'd0, rsp_error}, {31'd0, !p});
    if (op == 4 && p) exp_byte = 8'hFF;
    if (op == 4) check(p ? "R6 lock byte" : "R7 lock refused byte",
                       {24'd0, lock_byte}, {24'd0, exp_byte});
    else check("R5 byte unchanged", {24'd0, lock_byte}, {24'd0, exp_byte});
  endtask

  initial begin
    logic [7:0] inits [7] = '{8'h00, 8'h02, 8'h01, 8'h03, 8'hA4, 8'h5E, 8'hFF};
    foreach (inits[i]) begin
      do_reset(inits[i]);
      for (int op = 0; op < 8; op++) if (op != 4) do_cmd(op);
      do_cmd(4);
      for (int op = 0; op < 8; op++) do_cmd(op);
      do_cmd(4); // R7: repeat lock on a locked byte
      @(negedge clk);
      check("R9 single pulse", {31'd0, rsp_valid}, 32'd0);
      check("R9 hold error", {31'd0, rsp_error}, 32'd1);
      check("R1 id after ops", {16'd0, id_word}, {16'd0, 8'h5A, exp_byte});
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule